// File: doc/BRIEF.md
# Two-Step Flash Result Encoder

This block is the digital half of a two-step flash converter that reuses one bank of sixteen comparators for both of its flashes. A coarse estimator of six comparators picks one of seven ladder intervals. The encoder turns that pick into a tap index that points the comparator bank at a window of the 64-tap upper ladder. The window is sixteen taps wide and reaches four taps past each side of the estimated interval, so an estimator that is wrong by up to one sixteenth of full scale still produces the right six upper bits. The same bank is then switched onto the lower ladder to resolve the residue into four lower bits. The 10-bit code is latched and flagged.

A conversion is three enable-qualified cycles long. In the start cycle the estimator code is taken. In the coarse cycle the windowed comparator code is taken. In the fine cycle the lower-ladder comparator code is taken and the result register is written. Every thermometer code is reduced by counting its ones, so an isolated bubble does not throw the code off by a whole segment. The result leaves through a plain done strobe with no back-pressure. A result stays on `result` until the next conversion overwrites it, so a consumer has that long to take it. A start that arrives during a conversion, or without `en`, is dropped.

Top module: `multistep_encoder`

## Requirements
- R1: After reset, `result` is 0, `done` is 0, `fine_phase` is 0 and `tap_sel` is 0.
- R2: The estimator index k is the number of ones in `est_therm`. During the coarse cycle `tap_sel` equals 8k−4 clamped to 0..48, except that k=6 (every estimator bit set) gives 48.
- R3: The upper six bits of `result` equal the coarse `tap_sel` plus the number of ones in the coarse `cmp_therm`, saturated at 63.
- R4: During the fine cycle `fine_phase` is 1 and `tap_sel` carries the upper six bits just resolved. At all other times `fine_phase` is 0.
- R5: The lower four bits of `result` equal the number of ones in the fine `cmp_therm`, saturated at 15. `result` is {upper, lower}, with the upper bits in positions 9..4.
- R6: A start taken with `en` high in idle leads to `done` high for exactly one cycle, one cycle after the third enable-qualified cycle. `result` changes only together with `done`.
- R7: While `en` is low the sequence is frozen: `tap_sel` and `fine_phase` hold and `done` stays low.
- R8: `start` is ignored while a conversion is in progress, and also while `en` is low.
- R9: An analog input at the low reference gives code 0, and an input one LSB under the high reference gives code 1023.
- R10: An estimator error of up to 64 LSB still gives the exact code, as long as the true upper code lies inside the chosen window.
- R11: A thermometer code with a bubble is decoded by its ones count, not by its first transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Cycle qualifier; the sequence advances only when high |
| start | input | 1 | Begins a conversion when idle and `en` is high |
| est_therm | input | 6 | Estimator comparator thermometer code |
| cmp_therm | input | 16 | Shared comparator bank thermometer code |
| tap_sel | output | 6 | Window base tap (coarse) or resolved upper code (fine) |
| fine_phase | output | 1 | High while the bank must sit on the lower ladder |
| result | output | 10 | Latched conversion code |
| done | output | 1 | One-cycle strobe when `result` is written |

## Verification
The bench models the ladders and comparators around the encoder. It drives analog values from both rails, from mid-scale, and from just either side of the estimator thresholds. Estimator offsets of ±64 LSB separate a design that truly corrects errors through the overlapping window from one that trusts the estimate. Bubbled coarse codes separate ones-counting from transition finding. A forced all-ones bank exposes whether the upper and lower saturation is missing. Stalled, start-during-conversion and start-without-enable runs show whether the sequencer honours the qualifier and drops starts it should not take.

// File: rtl/ms_enc_pkg.sv
package ms_enc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_FINE   = 2'd2
  } phase_t;
endpackage

// File: rtl/ms_ones_count.sv
// Ones counter over a thermometer code; bubbles are absorbed by counting.
module ms_ones_count #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  therm,
  output logic [CW-1:0] ones
);
  logic [CW-1:0] part [W+1];

  assign part[0] = '0;
  for (genvar gi = 0; gi < W; gi++) begin : g_acc
    assign part[gi+1] = part[gi] + CW'(therm[gi]);
  end
  assign ones = part[W];
endmodule

// File: rtl/ms_window_map.sv
// Maps estimator interval index to the base tap of the overlapping window.
module ms_window_map #(
  parameter int EST_N    = 6,
  parameter int MSB_W    = 6,
  parameter int CMP_N    = 16,
  parameter int SEG_STEP = 8,
  parameter int WIN_OFF  = 4,
  parameter int ECW      = $clog2(EST_N + 1)
) (
  input  logic [ECW-1:0]   est_idx,
  output logic [MSB_W-1:0] base
);
  localparam int TOP = (2 ** MSB_W) - CMP_N;

  logic signed [31:0] raw;

  always_comb begin
    if (est_idx == ECW'(EST_N)) begin
      raw = 32'(TOP);
    end else begin
      raw = 32'(int'(est_idx) * SEG_STEP - WIN_OFF);
    end
    if (raw < 0) begin
      base = '0;
    end else if (raw > 32'(TOP)) begin
      base = MSB_W'(TOP);
    end else begin
      base = MSB_W'(raw);
    end
  end
endmodule

// File: rtl/ms_code_form.sv
// Saturating assembly of upper code from window base and lower code from count.
module ms_code_form #(
  parameter int MSB_W = 6,
  parameter int LSB_W = 4,
  parameter int CCW   = 5
) (
  input  logic [MSB_W-1:0] base,
  input  logic [CCW-1:0]   ones,
  output logic [MSB_W-1:0] msb_code,
  output logic [LSB_W-1:0] lsb_code
);
  localparam logic [MSB_W:0] MSB_LIM = (MSB_W+1)'((2 ** MSB_W) - 1);
  localparam logic [CCW-1:0] LSB_LIM = CCW'((2 ** LSB_W) - 1);

  logic [MSB_W:0] sum;

  always_comb begin
    sum = {1'b0, base} + (MSB_W+1)'(ones);
    if (sum > MSB_LIM) begin
      msb_code = MSB_LIM[MSB_W-1:0];
    end else begin
      msb_code = sum[MSB_W-1:0];
    end
    if (ones > LSB_LIM) begin
      lsb_code = LSB_LIM[LSB_W-1:0];
    end else begin
      lsb_code = ones[LSB_W-1:0];
    end
  end
endmodule

// File: rtl/ms_seq_ctrl.sv
// Three-step sequencer: estimate capture, coarse flash, fine flash and latch.
module ms_seq_ctrl
  import ms_enc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   start,
  output phase_t phase,
  output logic   cap_est,
  output logic   cap_msb,
  output logic   cap_res
);
  phase_t phase_d;

  always_comb begin
    cap_est = 1'b0;
    cap_msb = 1'b0;
    cap_res = 1'b0;
    phase_d = phase;
    unique case (phase)
      PH_IDLE: if (en && start) begin
        cap_est = 1'b1;
        phase_d = PH_COARSE;
      end
      PH_COARSE: if (en) begin
        cap_msb = 1'b1;
        phase_d = PH_FINE;
      end
      PH_FINE: if (en) begin
        cap_res = 1'b1;
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/multistep_encoder.sv
module multistep_encoder
  import ms_enc_pkg::*;
#(
  parameter int MSB_W    = 6,
  parameter int LSB_W    = 4,
  parameter int EST_N    = 6,
  parameter int CMP_N    = 16,
  parameter int SEG_STEP = 8,
  parameter int WIN_OFF  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   start,
  input  logic [EST_N-1:0]       est_therm,
  input  logic [CMP_N-1:0]       cmp_therm,
  output logic [MSB_W-1:0]       tap_sel,
  output logic                   fine_phase,
  output logic [MSB_W+LSB_W-1:0] result,
  output logic                   done
);
  localparam int RES_W = MSB_W + LSB_W;
  localparam int ECW   = $clog2(EST_N + 1);
  localparam int CCW   = $clog2(CMP_N + 1);

  phase_t           phase;
  logic             cap_est, cap_msb, cap_res;
  logic [ECW-1:0]   est_ones;
  logic [CCW-1:0]   cmp_ones;
  logic [ECW-1:0]   k_q;
  logic [MSB_W-1:0] win_base;
  logic [MSB_W-1:0] msb_d, msb_q;
  logic [LSB_W-1:0] lsb_d;
  logic [RES_W-1:0] res_q;
  logic             done_q;

  ms_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .start   (start),
    .phase   (phase),
    .cap_est (cap_est),
    .cap_msb (cap_msb),
    .cap_res (cap_res)
  );

  ms_ones_count #(.W(EST_N), .CW(ECW)) u_est_cnt (
    .therm (est_therm),
    .ones  (est_ones)
  );

  // One counter serves the shared bank in both flashes.
  ms_ones_count #(.W(CMP_N), .CW(CCW)) u_cmp_cnt (
    .therm (cmp_therm),
    .ones  (cmp_ones)
  );

  ms_window_map #(
    .EST_N    (EST_N),
    .MSB_W    (MSB_W),
    .CMP_N    (CMP_N),
    .SEG_STEP (SEG_STEP),
    .WIN_OFF  (WIN_OFF),
    .ECW      (ECW)
  ) u_win (
    .est_idx (k_q),
    .base    (win_base)
  );

  ms_code_form #(.MSB_W(MSB_W), .LSB_W(LSB_W), .CCW(CCW)) u_form (
    .base     (win_base),
    .ones     (cmp_ones),
    .msb_code (msb_d),
    .lsb_code (lsb_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= '0;
      msb_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cap_est) k_q   <= est_ones;
      if (cap_msb) msb_q <= msb_d;
      if (cap_res) res_q <= {msb_q, lsb_d};
      done_q <= cap_res;
    end
  end

  assign fine_phase = (phase == PH_FINE);
  assign tap_sel    = fine_phase ? msb_q : win_base;
  assign result     = res_q;
  assign done       = done_q;
endmodule

// File: rtl/multistep_encoder_chk.sv
module multistep_encoder_chk #(
  parameter int MSB_W = 6,
  parameter int RES_W = 10,
  parameter int CMP_N = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [MSB_W-1:0] tap_sel,
  input logic             fine_phase,
  input logic [RES_W-1:0] result,
  input logic             done
);
  localparam logic [MSB_W-1:0] TAP_TOP = MSB_W'((2 ** MSB_W) - CMP_N);

  // R6: strobe lasts one cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: strobe follows an enabled fine cycle
  p_done_after_fine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fine_phase && en));

  // R6: result moves only with the strobe
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R7: frozen while the qualifier is low
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(fine_phase) && $stable(tap_sel) && !done));

  // R4: the fine cycle ends when qualified
  p_fine_leaves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_phase && en) |=> !fine_phase);

  // R2: coarse window base never passes the top window position
  p_tap_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_phase |-> (tap_sel <= TAP_TOP));
endmodule

bind multistep_encoder multistep_encoder_chk #(
  .MSB_W (MSB_W),
  .RES_W (MSB_W + LSB_W),
  .CMP_N (CMP_N)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .tap_sel    (tap_sel),
  .fine_phase (fine_phase),
  .result     (result),
  .done       (done)
);

// File: tb/multistep_encoder_bench.sv
`timescale 1ns/1ps
module multistep_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  est_therm;
  logic [15:0] cmp_therm;
  logic [5:0]  tap_sel;
  logic        fine_phase;
  logic [9:0]  result;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int prev_res = 0;

  int cur_v = 0;
  int cur_e = 0;
  bit cur_b = 0;
  bit cur_o = 0;

  always #2 clk = ~clk;

  multistep_encoder u_multistep_encoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .start      (start),
    .est_therm  (est_therm),
    .cmp_therm  (cmp_therm),
    .tap_sel    (tap_sel),
    .fine_phase (fine_phase),
    .result     (result),
    .done       (done)
  );

  // Analog model: estimator thresholds at each eighth of full scale.
  function automatic logic [5:0] est_model(int s);
    logic [5:0] t;
    for (int i = 0; i < 6; i++) t[i] = (s >= 128 * (i + 1));
    return t;
  endfunction

  function automatic logic [15:0] cmp_model(int v, int tap, bit fine, bit bub, bit ovr);
    logic [15:0] t;
    int n;
    if (ovr) return '1;
    n = fine ? (v - 16 * tap) : ((v >> 4) - tap);
    if (n < 0) n = 0;
    if (n > 16) n = 16;
    for (int j = 0; j < 16; j++) t[j] = (j < n);
    if (bub && !fine && n >= 1 && n <= 15) begin
      t[n-1] = 1'b0;
      t[n]   = 1'b1;
    end
    return t;
  endfunction

  function automatic int exp_base(int s);
    int k = 0;
    int b;
    for (int i = 0; i < 6; i++) if (s >= 128 * (i + 1)) k++;
    if (k == 6) return 48;
    b = 8 * k - 4;
    if (b < 0) b = 0;
    if (b > 48) b = 48;
    return b;
  endfunction

  always_comb begin
    est_therm = est_model(cur_v + cur_e);
    cmp_therm = cmp_model(cur_v, int'(tap_sel), fine_phase, cur_b, cur_o);
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic conv(int v, int e, bit b, bit o, int stall, bit mid);
    int eb, ex, em;
    cur_v = v; cur_e = e; cur_b = b; cur_o = o;
    eb = exp_base(v + e);
    ex = o ? 1023 : v;
    em = o ? 63 : (v >> 4);
    @(negedge clk); start = 1'b1; en = 1'b1;
    @(negedge clk); start = mid;
    chk("R2 coarse tap_sel", int'(tap_sel), eb);
    chk("R4 coarse flag low", int'(fine_phase), 0);
    chk("R6 result held during conversion", int'(result), prev_res);
    if (stall > 0) begin
      en = 1'b0;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R7 coarse tap held", int'(tap_sel), eb);
        chk("R7 no done while stalled", int'(done), 0);
      end
      en = 1'b1;
    end
    @(negedge clk); start = 1'b0;
    chk("R4 fine flag high", int'(fine_phase), 1);
    chk("R4 R3 fine tap_sel upper code", int'(tap_sel), em);
    if (stall > 0) begin
      en = 1'b0;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R7 fine flag held", int'(fine_phase), 1);
        chk("R7 no done while stalled", int'(done), 0);
      end
      en = 1'b1;
    end
    @(negedge clk);
    chk("R6 done strobe", int'(done), 1);
    chk("R3 R5 result code", int'(result), ex);
    prev_res = ex;
    @(negedge clk);
    chk("R6 done single cycle", int'(done), 0);
    chk("R6 result stays", int'(result), ex);
    if (mid) begin
      @(negedge clk);
      chk("R8 start mid-conversion ignored", int'(fine_phase), 0);
      chk("R8 no extra done", int'(done), 0);
    end
  endtask

  localparam int NV = 17;
  localparam int VV [NV] = '{0, 1023, 512, 127, 128, 300, 639, 640, 767, 768, 900, 1000, 345, 757, 15, 1008, 383};
  localparam int EV [NV] = '{0, 0, 0, 64, -64, 0, 64, -64, -63, -64, 0, 30, 0, -20, 0, 0, -64};
  localparam bit BV [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 result at reset", int'(result), 0);
    chk("R1 done at reset", int'(done), 0);
    chk("R1 fine flag at reset", int'(fine_phase), 0);
    chk("R1 tap_sel at reset", int'(tap_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(fine_phase), 0);

    // Vector table: R2 R3 R5 R9 R10 R11
    for (int i = 0; i < NV; i++) conv(VV[i], EV[i], BV[i], 1'b0, 0, 1'b0);

    // R9 rails
    conv(0, 0, 1'b0, 1'b0, 0, 1'b0);
    conv(1023, 0, 1'b0, 1'b0, 0, 1'b0);

    // R3 R5 saturation: bank forced all ones in both flashes
    conv(1010, 0, 1'b0, 1'b1, 0, 1'b0);

    // R7 stalls in each phase
    conv(600, 0, 1'b0, 1'b0, 2, 1'b0);

    // R8 start held during conversion
    conv(450, 40, 1'b0, 1'b0, 0, 1'b1);

    // R8 start without qualifier is dropped
    cur_v = 200; cur_e = 0; cur_b = 0; cur_o = 0;
    @(negedge clk); en = 1'b0; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0; en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 no conversion without en", int'(fine_phase), 0);
    chk("R8 no done without en", int'(done), 0);
    chk("R8 result untouched", int'(result), prev_res);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule